// File: doc/BRIEF.md
# Page Write Buffer and Sequencer

This block sits between the serial front end of a small serial memory and its storage array. After a write opcode and start address are decoded, it gathers the following data bytes into a 16-byte page buffer. The column index starts at the low bits of the start address. When more bytes arrive than the page holds, the index wraps around inside the same page, so later bytes replace earlier ones.

The buffer is committed only when chip select rises at a clean byte boundary, after at least one data byte, with the write enable latch set and the target page outside the protected region. When those conditions hold, a self-timed cycle of `WC_CYCLES` clocks begins. The block holds `busy` high for the whole cycle and streams the loaded bytes to the array during the first clocks of the cycle. In the last clock it pulses `wel_clr` so that the status block can clear its write enable latch. While the cycle runs, the block drops every new command, byte and chip-select edge. `busy` is a plain output, so the status path can read it at any time.

Top module: `page_write_seq`

## Requirements
- R1: While reset is held and right after it is released, `busy`, `arr_we` and `wel_clr` are 0.
- R2: Data bytes are stored at the column given by `cmd_addr[3:0]`, and the column rises by one per byte. The column wraps from 15 to 0 inside the same page, and a later byte replaces an earlier one at the same column.
- R3: A cycle starts only on `cs_rise` with `cs_aligned`=1, after at least one data byte of an open write. `busy` is first seen high in the clock after `cs_rise`. If `cs_aligned`=0 or no data byte arrived, no cycle starts.
- R4: If `wel`=0 when `cs_rise` arrives, the write is refused and no cycle starts.
- R5: `bp` selects the protected region, judged on the page address bits `cmd_addr[10:4]`: 0 protects nothing, 1 protects pages whose two top bits are 11, 2 protects pages whose top bit is 1, and 3 protects every page. A write to a protected page starts no cycle.
- R6: Once started, `busy` stays high for exactly `WC_CYCLES` clocks, then drops.
- R7: During the cycle, the block issues exactly one `arr_we` per loaded column, in ascending column order, with `arr_addr` = {page, column}. Columns that received no byte are not written.
- R8: `wel_clr` is a single-clock pulse in the last clock of a started cycle, and it never occurs without one.
- R9: While `busy` is high, including its last clock, write commands, data bytes and `cs_rise` are ignored. No second cycle and no extra array writes follow from them.
- R10: Outside an open write, data bytes and `cs_rise` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | One-clock strobe: an opcode has been decoded |
| cmd_is_write | input | 1 | The decoded opcode is an array write |
| cmd_addr | input | ADDR_W | Start byte address of the write |
| byte_valid | input | 1 | One-clock strobe: a complete data byte is available |
| byte_data | input | 8 | Data byte |
| cs_rise | input | 1 | One-clock strobe: chip select has gone inactive |
| cs_aligned | input | 1 | The bit count was a whole number of bytes at `cs_rise` |
| wel | input | 1 | Write enable latch state from the status block |
| bp | input | 2 | Block protection selection from the status block |
| busy | output | 1 | Self-timed write cycle in progress |
| wel_clr | output | 1 | Completion pulse; the status block clears its enable latch |
| arr_we | output | 1 | Array byte write strobe |
| arr_addr | output | ADDR_W | Array byte address |
| arr_wdata | output | 8 | Array byte data |

## Verification
The end of the self-timed cycle and the arrival of a new write command can fall on the same clock: `wel_clr` is high there and `busy` has not yet dropped. The bench waits for the clock in which it observes `wel_clr` and issues a write command with data and a clean `cs_rise` starting in that very clock. Correct behaviour is that `busy` stays low afterwards, that no array write reaches the intruding page, and that the original cycle lasted exactly `WC_CYCLES` clocks. A second intrusion in the middle of a cycle is judged the same way.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_BUSY = 2'd2
  } seq_state_e;
endpackage

// File: rtl/pwb_page_buf.sv
module pwb_page_buf
  import pwb_pkg::*;
#(
  parameter int PAGE_BYTES = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic [$clog2(PAGE_BYTES)-1:0] start_col_i,
  input  logic                          wr_en_i,
  input  logic [BYTE_W-1:0]             wr_data_i,
  input  logic [$clog2(PAGE_BYTES)-1:0] rd_idx_i,
  output logic [BYTE_W-1:0]             rd_data_o,
  output logic                          rd_loaded_o,
  output logic                          any_loaded_o
);
  localparam int COL_W = $clog2(PAGE_BYTES);

  logic [COL_W-1:0]         col_q, col_d;
  logic [PAGE_BYTES-1:0]    mask_q, mask_d;
  logic [PAGE_BYTES*BYTE_W-1:0] slots_flat;
  logic                     store_en;

  assign store_en = wr_en_i && !start_i;

  always_comb begin
    col_d  = col_q;
    mask_d = mask_q;
    if (start_i) begin
      col_d  = start_col_i;
      mask_d = '0;
    end else if (wr_en_i) begin
      col_d         = col_q + 1'b1;
      mask_d[col_q] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      mask_q <= '0;
    end else begin
      col_q  <= col_d;
      mask_q <= mask_d;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic [BYTE_W-1:0] data_q;
    logic              slot_en;
    assign slot_en = store_en && (col_q == COL_W'(g));
    always_ff @(posedge clk) begin
      if (slot_en) data_q <= wr_data_i;
    end
    assign slots_flat[g*BYTE_W +: BYTE_W] = data_q;
  end

  assign rd_data_o    = slots_flat[rd_idx_i*BYTE_W +: BYTE_W];
  assign rd_loaded_o  = mask_q[rd_idx_i];
  assign any_loaded_o = |mask_q;

  // R2: column wraps inside the page after the last slot
  assert_col_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (store_en && col_q == COL_W'(PAGE_BYTES-1)) |=> (col_q == '0));

  // R2: a new write command empties the page
  assert_mask_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (mask_q == '0));
endmodule

// File: rtl/pwb_protect.sv
module pwb_protect #(
  parameter int PAGE_W = 7
) (
  input  logic [PAGE_W-1:0] page_i,
  input  logic [1:0]        bp_i,
  output logic              locked_o
);
  logic [1:0] top2;
  assign top2 = page_i[PAGE_W-1 -: 2];

  always_comb begin
    unique case (bp_i)
      2'd0:    locked_o = 1'b0;
      2'd1:    locked_o = &top2;
      2'd2:    locked_o = top2[1];
      default: locked_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/pwb_cycle_timer.sv
module pwb_cycle_timer #(
  parameter int WC_CYCLES = 1000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic                         run_i,
  output logic [$clog2(WC_CYCLES)-1:0] cnt_o,
  output logic                         last_o
);
  localparam int CNT_W = $clog2(WC_CYCLES);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (start_i)    cnt_d = '0;
    else if (run_i) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o  = cnt_q;
  assign last_o = run_i && (cnt_q == CNT_W'(WC_CYCLES-1));

  // R6: the count never runs past the cycle length while running
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |-> (32'(cnt_q) < WC_CYCLES));
endmodule

// File: rtl/page_write_seq.sv
module page_write_seq
  import pwb_pkg::*;
#(
  parameter int ADDR_W     = 11,
  parameter int PAGE_BYTES = 16,
  parameter int WC_CYCLES  = 1000   // must exceed PAGE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_is_write,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              cs_rise,
  input  logic              cs_aligned,
  input  logic              wel,
  input  logic [1:0]        bp,
  output logic              busy,
  output logic              wel_clr,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [7:0]        arr_wdata
);
  localparam int COL_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - COL_W;
  localparam int CNT_W  = $clog2(WC_CYCLES);

  seq_state_e        st_q, st_d;
  logic [PAGE_W-1:0] page_q, page_d;

  logic             open_cmd, fill_wr, seq_ok, go, locked, any_loaded;
  logic             tmr_last, in_commit, slot_loaded;
  logic [CNT_W-1:0] tmr_cnt;
  logic [COL_W-1:0] commit_col;
  logic [7:0]       slot_data;

  assign open_cmd = (st_q == ST_IDLE) && cmd_valid && cmd_is_write;
  assign fill_wr  = (st_q == ST_FILL) && byte_valid;
  assign seq_ok   = any_loaded && cs_aligned && wel && !locked;
  assign go       = (st_q == ST_FILL) && cs_rise && seq_ok;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (open_cmd) st_d = ST_FILL;
      ST_FILL: if (cs_rise)  st_d = seq_ok ? ST_BUSY : ST_IDLE;
      ST_BUSY: if (tmr_last) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    page_d = page_q;
    if (open_cmd) page_d = cmd_addr[ADDR_W-1:COL_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      page_q <= '0;
    end else begin
      st_q   <= st_d;
      page_q <= page_d;
    end
  end

  pwb_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (open_cmd),
    .start_col_i (cmd_addr[COL_W-1:0]),
    .wr_en_i     (fill_wr),
    .wr_data_i   (byte_data),
    .rd_idx_i    (commit_col),
    .rd_data_o   (slot_data),
    .rd_loaded_o (slot_loaded),
    .any_loaded_o(any_loaded)
  );

  pwb_protect #(.PAGE_W(PAGE_W)) u_prot (
    .page_i  (page_q),
    .bp_i    (bp),
    .locked_o(locked)
  );

  pwb_cycle_timer #(.WC_CYCLES(WC_CYCLES)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(go),
    .run_i  (busy),
    .cnt_o  (tmr_cnt),
    .last_o (tmr_last)
  );

  assign busy       = (st_q == ST_BUSY);
  assign commit_col = COL_W'(tmr_cnt);
  assign in_commit  = busy && (32'(tmr_cnt) < PAGE_BYTES);
  assign arr_we     = in_commit && slot_loaded;
  assign arr_addr   = {page_q, commit_col};
  assign arr_wdata  = slot_data;
  assign wel_clr    = tmr_last;

  // R3: busy only rises after an aligned chip-select edge
  assert_busy_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_rise && cs_aligned));

  // R4: a clear enable latch blocks the cycle
  assert_refuse_wel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_FILL) && cs_rise && !wel) |=> !busy);

  // R5: a protected page blocks the cycle
  assert_refuse_prot_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == ST_FILL) && cs_rise && locked) |=> !busy);

  // R7: array writes only happen inside a cycle
  assert_we_in_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  // R8: completion pulse is the last busy clock
  assert_done_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wel_clr |-> busy ##1 !busy);

  // R9: nothing ends a cycle early
  assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wel_clr) |=> busy);
endmodule

// File: tb/page_write_seq_tb.sv
`timescale 1ns/1ps
module page_write_seq_tb;
  localparam int ADDR_W = 11;
  localparam int PB     = 16;
  localparam int WC     = 40;

  logic clk, rst_n;
  logic cmd_valid, cmd_is_write, byte_valid, cs_rise, cs_aligned, wel;
  logic [ADDR_W-1:0] cmd_addr;
  logic [7:0] byte_data;
  logic [1:0] bp;
  logic busy, wel_clr, arr_we;
  logic [ADDR_W-1:0] arr_addr;
  logic [7:0] arr_wdata;

  page_write_seq #(.ADDR_W(ADDR_W), .PAGE_BYTES(PB), .WC_CYCLES(WC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_is_write(cmd_is_write),
    .cmd_addr(cmd_addr), .byte_valid(byte_valid), .byte_data(byte_data),
    .cs_rise(cs_rise), .cs_aligned(cs_aligned), .wel(wel), .bp(bp),
    .busy(busy), .wel_clr(wel_clr), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  int busy_cnt, clr_cnt, cap_cnt, bad_page, order_bad, prev_col;
  logic [6:0] exp_page;
  logic [7:0] cap_data [PB];
  logic [PB-1:0] cap_mask;

  typedef struct packed {
    logic [3:0] col;
    logic [6:0] page;
    logic [5:0] n;
    logic       al;
    logic       we;
    logic [1:0] b;
    logic       exp;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{4'd0,  7'd3,   6'd16, 1'b1, 1'b1, 2'd0, 1'b1},  // full page
    '{4'd10, 7'd5,   6'd20, 1'b1, 1'b1, 2'd0, 1'b1},  // wrap, mid-cycle intrusion
    '{4'd5,  7'd9,   6'd3,  1'b1, 1'b1, 2'd0, 1'b1},  // partial
    '{4'd2,  7'd9,   6'd0,  1'b1, 1'b1, 2'd0, 1'b0},  // no data byte
    '{4'd2,  7'd9,   6'd4,  1'b0, 1'b1, 2'd0, 1'b0},  // unaligned end
    '{4'd0,  7'd12,  6'd4,  1'b1, 1'b0, 2'd0, 1'b0},  // latch clear
    '{4'd0,  7'd112, 6'd2,  1'b1, 1'b1, 2'd1, 1'b0},  // top quarter locked
    '{4'd0,  7'd80,  6'd2,  1'b1, 1'b1, 2'd1, 1'b1},  // top half, quarter mode
    '{4'd0,  7'd80,  6'd2,  1'b1, 1'b1, 2'd2, 1'b0},  // top half locked
    '{4'd7,  7'd32,  6'd2,  1'b1, 1'b1, 2'd2, 1'b1},  // lower half free
    '{4'd0,  7'd0,   6'd2,  1'b1, 1'b1, 2'd3, 1'b0}   // all locked
  };

  function automatic logic [7:0] dbyte(int s, int i);
    return 8'(s * 37 + i * 11 + 5);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) busy_cnt++;
      if (wel_clr) clr_cnt++;
      if (arr_we) begin
        if (cap_cnt > 0 && int'(arr_addr[3:0]) <= prev_col) order_bad++;
        prev_col = int'(arr_addr[3:0]);
        cap_cnt++;
        cap_data[arr_addr[3:0]] = arr_wdata;
        cap_mask[arr_addr[3:0]] = 1'b1;
        if (arr_addr[10:4] != exp_page) bad_page++;
      end
    end
  end

  task automatic clear_obs(input logic [6:0] pg);
    busy_cnt = 0; clr_cnt = 0; cap_cnt = 0; bad_page = 0; order_bad = 0;
    prev_col = -1; cap_mask = '0; exp_page = pg;
  endtask

  // called at a negedge; returns at the negedge after the chip-select edge
  task automatic send(input logic [3:0] col, input logic [6:0] pg, input int n,
                      input logic al, input int seed);
    cmd_valid = 1'b1; cmd_is_write = 1'b1; cmd_addr = {pg, col};
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < n; i++) begin
      byte_valid = 1'b1; byte_data = dbyte(seed, i);
      @(negedge clk);
    end
    byte_valid = 1'b0;
    cs_rise = 1'b1; cs_aligned = al;
    @(negedge clk);
    cs_rise = 1'b0;
  endtask

  task automatic wait_idle();
    int g = 0;
    while (busy && g < 1000) begin
      @(negedge clk);
      g++;
    end
    @(negedge clk);
  endtask

  task automatic judge(input logic exp, input logic [3:0] col, input int n, input int seed);
    int bad = 0;
    int ecnt = exp ? ((n > PB) ? PB : n) : 0;
    chk(busy_cnt == (exp ? WC : 0), "R6 busy length", busy_cnt, exp ? WC : 0);
    chk(clr_cnt == (exp ? 1 : 0), "R8 wel_clr pulses", clr_cnt, exp ? 1 : 0);
    chk(cap_cnt == ecnt, "R7 array write count", cap_cnt, ecnt);
    chk(bad_page == 0 && order_bad == 0, "R7 address/order", bad_page + order_bad, 0);
    if (exp) begin
      for (int j = 0; j < PB; j++) begin
        logic has = 1'b0;
        logic [7:0] ed = '0;
        for (int i = 0; i < n; i++)
          if (((int'(col) + i) % PB) == j) begin has = 1'b1; ed = dbyte(seed, i); end
        if (cap_mask[j] != has || (has && cap_data[j] != ed)) bad++;
      end
      chk(bad == 0, "R2 page contents", bad, 0);
    end
  endtask

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_is_write = 1'b0; cmd_addr = '0;
    byte_valid = 1'b0; byte_data = '0; cs_rise = 1'b0; cs_aligned = 1'b1;
    wel = 1'b1; bp = 2'd0;
    clear_obs(7'd0);
    repeat (3) @(negedge clk);
    chk(!busy && !arr_we && !wel_clr, "R1 during reset", {busy, arr_we, wel_clr}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !arr_we && !wel_clr, "R1 after reset", {busy, arr_we, wel_clr}, 0);

    // R10: stray bytes and chip-select edge with no open write
    byte_valid = 1'b1; byte_data = 8'h5a;
    @(negedge clk);
    byte_valid = 1'b0; cs_rise = 1'b1; cs_aligned = 1'b1;
    @(negedge clk);
    cs_rise = 1'b0;
    @(negedge clk);
    chk(!busy && cap_cnt == 0, "R10 stray input", busy, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      wel = t.we; bp = t.b;
      clear_obs(t.page);
      @(negedge clk);
      send(t.col, t.page, int'(t.n), t.al, v);
      chk(busy == t.exp, "R3/R4/R5 start decision", busy, t.exp);
      if (v == 1) begin
        // R9: intrusion in the middle of the cycle
        repeat (3) @(negedge clk);
        send(4'd0, 7'd1, 2, 1'b1, 99);
        chk(busy == 1'b1, "R9 mid-cycle intrusion", busy, 1);
      end
      wait_idle();
      judge(t.exp, t.col, int'(t.n), v);
    end

    // R9: a write command in the same clock as the completion pulse
    wel = 1'b1; bp = 2'd0;
    clear_obs(7'd17);
    @(negedge clk);
    send(4'd4, 7'd17, 2, 1'b1, 50);
    begin
      int g = 0;
      while (!wel_clr && g < 1000) begin @(negedge clk); g++; end
    end
    send(4'd0, 7'd2, 2, 1'b1, 51);
    chk(!busy, "R9 command at completion", busy, 0);
    repeat (PB + 4) @(negedge clk);
    chk(!busy, "R9 no late start", busy, 0);
    judge(1'b1, 4'd4, 2, 50);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule